// File: doc/BRIEF.md
# Streaming 8x8 Integer Matrix Multiplier

This block takes two 8x8 matrices of 32-bit integers on one AXI4-Stream input and returns their 8x8 product on an AXI4-Stream output. Both streams are 512 bits wide, so each beat carries 16 elements. A job is eight input beats and four output beats. The first four input beats hold the left operand A and the next four hold the right operand B, both in row-major order. The output beats hold C = A x B in row-major order.

The block has no control registers and no TUSER, TID or TDEST sideband. A block-level `go` input lets it start a new load once a result has been fully delivered. If `go` is tied high, the block re-arms by itself and handles jobs back to back. A single multiply-accumulate unit computes the product one term per clock cycle. It holds both operands in local storage while it computes. The output follows TVALID/TREADY handshaking only, so a consumer that becomes ready late still receives every beat.

Top module: `mm_stream_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `s_tready` is 1 and `m_tvalid` is 0. The block is waiting for the first beat of A.
- R2: Element s of an input beat occupies bits [32s+31:32s]. Accepted beat b (0 to 7) carries job element 16b+s. Elements 0 to 63 are A and elements 64 to 127 are B, each row-major (element r*8+c is row r, column c). Beats are assigned by handshake count alone.
- R3: After the eighth beat of a job is accepted, `s_tready` stays 0 through the whole computation and output phase. Input offered in that time is not consumed.
- R4: Each result element C[i][j] equals the sum over k of A[i][k]*B[k][j], computed in 32-bit two's-complement arithmetic that wraps on overflow.
- R5: A result leaves as exactly four beats with the same packing as the input. Output beat q slot s carries C element 16q+s, row-major. `m_tlast` is 1 on the fourth beat and 0 on the other three.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values on the next cycle.
- R7: After the fourth output beat is accepted, the block raises `s_tready` again only once `go` is 1. With `go` low, `s_tready` and `m_tvalid` both stay 0.
- R8: `m_tvalid` rises exactly 512 clock cycles after the clock edge that accepts the last B beat, which is one cycle per multiply-accumulate term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Block-level start; may be held at 1 |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready |
| s_tdata | input | 512 | Input beat, 16 elements of 32 bits |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | 512 | Output beat, 16 result elements |
| m_tlast | output | 1 | Marks the fourth beat of a result |

## Verification
The in-line assertions check properties that must hold on every clock cycle:
- the input is closed whenever output is valid;
- held output stays stable under backpressure;
- valid drops after the last output beat;
- the input beat counter moves only on a handshake;
- the compute-done pulse lasts one cycle;
- the block stays closed while `go` is low in the idle state.

Other properties can only be shown by the bench's scenarios: the arithmetic, including wrap-around with extreme operands, the element-to-lane ordering of both operands and the result, the exact 512-cycle latency, and whether stalled back-to-back jobs come out correct. The bench shows these by comparing whole jobs, with and without random output backpressure, against a product it computes itself.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int unsigned DIM        = 8;
    localparam int unsigned ELEM_W     = 32;
    localparam int unsigned BEAT_W     = 512;
    localparam int unsigned EPB        = BEAT_W / ELEM_W;
    localparam int unsigned OPND       = DIM * DIM;
    localparam int unsigned OPND_BEATS = OPND / EPB;
    localparam int unsigned IN_BEATS   = 2 * OPND_BEATS;
    localparam int unsigned DIM_W      = $clog2(DIM);
    localparam int unsigned SLOT_W     = $clog2(EPB);
    localparam int unsigned CNT_W      = $clog2(IN_BEATS);
    localparam int unsigned OUT_CNT_W  = $clog2(OPND_BEATS);

    typedef logic [ELEM_W-1:0] elem_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_COMPUTE,
        ST_EMIT
    } mm_state_e;

    // One multiply-accumulate step, wrapping modulo 2^ELEM_W.
    function automatic elem_t mac_step(elem_t acc, elem_t a, elem_t b);
        elem_t prod;
        prod = a * b;
        return acc + prod;
    endfunction
endpackage

// File: rtl/mm_loader.sv
module mm_loader
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [BEAT_W-1:0] beat,
    output logic [CNT_W-1:0]  cnt,
    output elem_t             elems [2*OPND]
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
            for (int s = 0; s < EPB; s++) begin
                elems[{cnt, SLOT_W'(s)}] <= beat[s*ELEM_W +: ELEM_W];
            end
        end
    end

    // R2: operand split is by handshake count only
    a_r2_count_on_take: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cnt));
endmodule

// File: rtl/mm_mac.sv
module mm_mac
    import mm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  elem_t elems [2*OPND],
    output elem_t c_elems [OPND],
    output logic  done
);
    logic [DIM_W-1:0] ri, rj, rk;
    elem_t            acc, a_v, b_v, sum;
    logic             last_k;

    always_comb begin
        a_v    = elems[{1'b0, ri, rk}];
        b_v    = elems[{1'b1, rk, rj}];
        sum    = mac_step((rk == '0) ? '0 : acc, a_v, b_v);
        last_k = (rk == DIM_W'(DIM - 1));
        done   = run && last_k && (ri == DIM_W'(DIM - 1)) && (rj == DIM_W'(DIM - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ri  <= '0;
            rj  <= '0;
            rk  <= '0;
            acc <= '0;
        end else begin
            acc <= sum;
            rk  <= rk + 1'b1;
            if (last_k) begin
                c_elems[{ri, rj}] <= sum;
                rj <= rj + 1'b1;
                if (rj == DIM_W'(DIM - 1)) ri <= ri + 1'b1;
            end
        end
    end

    // R8: completion is a single-cycle event per job
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/mm_emitter.sv
module mm_emitter
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              m_tready,
    input  elem_t             c_elems [OPND],
    output logic              m_tvalid,
    output logic [BEAT_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              finished
);
    logic [OUT_CNT_W-1:0] ocnt;

    always_comb begin
        m_tvalid = active;
        m_tlast  = active && (ocnt == OUT_CNT_W'(OPND_BEATS - 1));
        finished = active && m_tready && m_tlast;
        for (int s = 0; s < EPB; s++) begin
            m_tdata[s*ELEM_W +: ELEM_W] = c_elems[{ocnt, SLOT_W'(s)}];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ocnt <= '0;
        else if (active && m_tready) ocnt <= ocnt + 1'b1;
    end

    a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    a_r5_last_ends_result: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);
endmodule

// File: rtl/mm_stream_top.sv
module mm_stream_top
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [BEAT_W-1:0] s_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [BEAT_W-1:0] m_tdata,
    output logic              m_tlast
);
    mm_state_e        state, state_nx;
    logic [CNT_W-1:0] in_cnt;
    logic             take, mac_done, out_done;
    elem_t            op_elems [2*OPND];
    elem_t            res_elems [OPND];

    assign s_tready = (state == ST_LOAD_A) || (state == ST_LOAD_B);
    assign take     = s_tvalid && s_tready;

    mm_loader u_loader (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .beat  (s_tdata),
        .cnt   (in_cnt),
        .elems (op_elems)
    );

    mm_mac u_mac (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_COMPUTE),
        .elems   (op_elems),
        .c_elems (res_elems),
        .done    (mac_done)
    );

    mm_emitter u_emit (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_EMIT),
        .m_tready (m_tready),
        .c_elems  (res_elems),
        .m_tvalid (m_tvalid),
        .m_tdata  (m_tdata),
        .m_tlast  (m_tlast),
        .finished (out_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (go) state_nx = ST_LOAD_A;
            ST_LOAD_A:  if (take && in_cnt == CNT_W'(OPND_BEATS - 1)) state_nx = ST_LOAD_B;
            ST_LOAD_B:  if (take && in_cnt == CNT_W'(IN_BEATS - 1)) state_nx = ST_COMPUTE;
            ST_COMPUTE: if (mac_done) state_nx = ST_EMIT;
            ST_EMIT:    if (out_done) state_nx = ST_IDLE;
            default:    state_nx = ST_LOAD_A;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOAD_A;
        else     state <= state_nx;
    end

    a_r3_closed_while_output: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> !s_tready);

    a_r7_wait_for_go: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !go) |=> !s_tready);
endmodule

// File: tb/mm_stream_top_test.sv
`timescale 1ns/1ps
module mm_stream_top_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b1;
    logic         s_tvalid = 1'b0;
    logic         s_tready;
    logic [511:0] s_tdata = '0;
    logic         m_tvalid;
    logic         m_tready = 1'b0;
    logic [511:0] m_tdata;
    logic         m_tlast;

    always #2.5 clk = ~clk;

    mm_stream_top uut (
        .clk(clk), .rst(rst), .go(go),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit bp_on = 1'b0;
    bit finished_run = 1'b0;

    logic [511:0] exp_q [$];
    int           ts_q [$];
    logic [31:0]  ja [64];
    logic [31:0]  jb [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_beat(input logic [511:0] d, input bit mark);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = d;
        forever begin
            if (s_tready) begin
                if (mark) ts_q.push_back(cyc + 1);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        s_tvalid = 1'b0;
    endtask

    // Scoreboard driver: push expected result beats, then send A and B beats.
    task automatic send_job();
        logic [31:0]  acc;
        logic [31:0]  c [64];
        logic [511:0] beat;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                acc = '0;
                for (int k = 0; k < 8; k++) acc = acc + ja[i*8+k] * jb[k*8+j];
                c[i*8+j] = acc;
            end
        for (int q = 0; q < 4; q++) begin
            for (int s = 0; s < 16; s++) beat[s*32 +: 32] = c[q*16+s];
            exp_q.push_back(beat);
        end
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 16; s++)
                beat[s*32 +: 32] = (b < 4) ? ja[b*16+s] : jb[(b-4)*16+s];
            drive_beat(beat, b == 7);
        end
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: drives output ready, pops expected beats and compares.
    bit           prev_v = 1'b0;
    bit           prev_r = 1'b0;
    logic [511:0] prev_d = '0;
    int           obeat = 0;
    int           t0;
    logic [511:0] expb;
    always @(negedge clk) begin
        if (mon_on) begin
            m_tready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (m_tvalid && !prev_v) begin
                if (ts_q.size() == 0) check(1'b0, "R8 no pending job", 512'(cyc), 0);
                else begin
                    t0 = ts_q.pop_front();
                    check(cyc - t0 == 512, "R8 latency", 512'(cyc - t0), 512);
                end
            end
            if (prev_v && !prev_r)
                check(m_tvalid && m_tdata == prev_d, "R6 hold under stall", m_tdata, prev_d);
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) check(1'b0, "R5 unexpected beat", m_tdata, 0);
                else begin
                    expb = exp_q.pop_front();
                    check(m_tdata == expb, "R4 R5 result beat", m_tdata, expb);
                    check(m_tlast == (obeat == 3), "R5 tlast position", 512'(m_tlast), 512'(obeat == 3));
                end
                obeat = (obeat + 1) % 4;
            end
            prev_v = m_tvalid;
            prev_r = m_tready;
            prev_d = m_tdata;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !finished_run) begin
            errors++;
            $display("FAIL watchdog actual %0d expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(s_tready == 1'b1 && m_tvalid == 1'b0, "R1 during reset", {s_tready, m_tvalid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        check(s_tready == 1'b1 && m_tvalid == 1'b0, "R1 after reset", {s_tready, m_tvalid}, 2'b10);
        mon_on = 1'b1;

        // Job 1 (R2, R4): identity times an index-valued matrix.
        for (int e = 0; e < 64; e++) begin
            ja[e] = (e / 8 == e % 8) ? 32'd1 : 32'd0;
            jb[e] = 32'(e * 3 + 1);
        end
        send_job();

        // Job 2 (R2, R4, R6): random operands under output backpressure.
        bp_on = 1'b1;
        for (int e = 0; e < 64; e++) begin
            ja[e] = $urandom();
            jb[e] = $urandom();
        end
        send_job();

        // R3: offered input during compute is refused.
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = {16{32'hDEAD_BEEF}};
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (n % 5 == 0) check(s_tready == 1'b0, "R3 input closed while busy", 512'(s_tready), 0);
        end
        s_tvalid = 1'b0;

        // Job 3 (R4): extremes that overflow and wrap.
        for (int e = 0; e < 64; e++) begin
            ja[e] = (e % 2 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
            jb[e] = (e % 3 == 0) ? 32'h8000_0000 : 32'hFFFF_FFFF;
        end
        send_job();
        wait_drained();
        bp_on = 1'b0;

        // Job 4 then hold go low (R7).
        go = 1'b0;
        for (int e = 0; e < 64; e++) begin
            ja[e] = 32'($signed($urandom_range(0, 200)) - 100);
            jb[e] = 32'($signed($urandom_range(0, 200)) - 100);
        end
        send_job();
        wait_drained();
        s_tvalid = 1'b1;
        s_tdata  = {16{32'h1234_5678}};
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            if (n % 3 == 0)
                check(s_tready == 1'b0 && m_tvalid == 1'b0, "R7 idle while go low", {s_tready, m_tvalid}, 2'b00);
        end
        s_tvalid = 1'b0;
        go = 1'b1;
        @(negedge clk);
        check(s_tready == 1'b1, "R7 re-armed by go", 512'(s_tready), 1);

        // Job 5 (R4, R6): random with backpressure.
        bp_on = 1'b1;
        for (int e = 0; e < 64; e++) begin
            ja[e] = $urandom();
            jb[e] = $urandom();
        end
        send_job();
        wait_drained();
        repeat (5) @(negedge clk);
        check(ts_q.size() == 0, "R8 all jobs timed", 512'(ts_q.size()), 0);

        finished_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule